// File: doc/BRIEF.md
# Internal Oscillator Frequency Selector with Glitch-Free System Clock Switch

The block builds an internal oscillator clock from three free-running reference clocks. It then chooses the chip's system clock among a primary clock, a secondary clock and that internal clock. A high-frequency reference, nominally 16 MHz, feeds a binary postscaler. A 3-bit rate code picks the undivided reference or one of its power-of-two divisions. For the slowest rate, a 2-bit source field decides which reference supplies the nominal 31.25 kHz clock. The choices are the low-frequency reference itself, the deepest postscaler stage, or a divided copy of the medium-frequency reference.

A separate watchdog clock output follows the low-frequency reference at all times, whatever the rate and source fields hold. The system clock is selected by a 2-bit field. A change of source goes through a handshake that releases the old clock on its falling edge. It then lets the new clock through only after two of its own rising edges, and a busy flag covers the whole exchange. A write strobe captures all three configuration fields together on the high-frequency clock. Three ready flags report when each reference has run for a fixed number of its own cycles after reset.

Top module: `iosc_freq_sel`

## Requirements
- R1: For rate codes 001 to 111, `intosc_clk` is the high-frequency reference divided by 2^(7 - code) with equal high and low times: 111 is the reference itself (16 MHz), 110 is 8 MHz, 101 is 4 MHz, 100 is 2 MHz, 011 is 1 MHz, 010 is 500 kHz and 001 is 250 kHz. The source field has no effect on these codes.
- R2: With rate code 000 and source field bit 1 equal to 0, `intosc_clk` is the low-frequency reference.
- R3: With rate code 000 and source field 10, `intosc_clk` is the high-frequency reference divided by 2^HF_DIV_W (512 by default, 31.25 kHz).
- R4: With rate code 000 and source field 11, `intosc_clk` is the medium-frequency reference divided by 2^MF_LO_DIV_W (16 by default).
- R5: Reset sets the rate code to 011 and the source field to 00, so `intosc_clk` runs at 1 MHz until the first write.
- R6: `wdt_clk` always equals the low-frequency reference, under every rate code and source field.
- R7: A new rate code takes effect at the high-frequency edge that captures the write. When the internal clock already drives the system clock, `sys_clk` changes rate with no switch sequence and `switch_busy` stays low.
- R8: Reset clears the system select field to 00 (primary). While reset is held, no source is enabled, `sys_clk` is low and `switch_busy` is high. After release, `sys_clk` follows `pri_clk`.
- R9: The system select field decodes 00 to `pri_clk`, 01 to `sec_clk`, and 10 or 11 to `intosc_clk`. A write that moves between 10 and 11 starts no switch.
- R10: A write that selects a different source raises `switch_busy` at the capturing edge. The old source is gated off on its falling edge. The new one is gated on at a falling edge after two of its own rising edges. At most one source is enabled at any time, and `sys_clk` shows no high or low pulse shorter than the shorter half-period of the two clocks.
- R11: `hf_ready`, `mf_ready` and `lf_ready` are low from reset and rise after READY_CYCLES rising edges of their own reference. Each then stays high until the next reset.
- R12: While `cfg_wr` is low, the rate code, source field and system select field hold their values, whatever is on the configuration inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hf_clk | input | 1 | High-frequency reference, nominal 16 MHz; also clocks the configuration fields |
| mf_clk | input | 1 | Medium-frequency reference |
| lf_clk | input | 1 | Low-frequency reference, nominal 31.25 kHz |
| pri_clk | input | 1 | Primary system clock candidate |
| sec_clk | input | 1 | Secondary system clock candidate |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Write strobe for all configuration fields |
| cfg_freq | input | 3 | Rate code |
| cfg_lo_src | input | 2 | Source field for rate code 000 |
| cfg_sys | input | 2 | System clock select field |
| intosc_clk | output | 1 | Internal oscillator clock |
| wdt_clk | output | 1 | Watchdog and clock monitor clock |
| sys_clk | output | 1 | Selected system clock |
| switch_busy | output | 1 | High while the system clock source differs from the selection |
| hf_ready | output | 1 | High-frequency reference has run READY_CYCLES cycles |
| mf_ready | output | 1 | Medium-frequency reference has run READY_CYCLES cycles |
| lf_ready | output | 1 | Low-frequency reference has run READY_CYCLES cycles |

## Verification
The hardest case to reach from the ports is the switch itself. Two asynchronous clocks hand over control, and a clipped pulse on either side would be the failure. The stimulus drives every reference and candidate clock with its own unrelated period. It then steps the system select through primary, secondary, internal and back. During each exchange, a pulse-width monitor records the shortest high and low time seen on `sys_clk`. The 31.25 kHz sources are told apart by giving the low and medium references periods that differ slightly from nominal, so each source choice yields its own measurable period.

// File: rtl/iosc_pkg.sv
`timescale 1ns/1ps
package iosc_pkg;
  localparam int CODE_W = 3;
  localparam int SRC_N  = 3;
  localparam int SRC_PRI = 0;
  localparam int SRC_SEC = 1;
  localparam int SRC_INT = 2;

  // Number of binary postscaler stages behind a rate code (top code = 0 stages).
  function automatic int post_shift(input logic [CODE_W-1:0] code);
    return (2**CODE_W - 1) - int'(code);
  endfunction

  // System select field to one-hot source vector.
  function automatic logic [SRC_N-1:0] sys_decode(input logic [1:0] field);
    logic [SRC_N-1:0] oh;
    oh = '0;
    if (field[1])      oh[SRC_INT] = 1'b1;
    else if (field[0]) oh[SRC_SEC] = 1'b1;
    else               oh[SRC_PRI] = 1'b1;
    return oh;
  endfunction
endpackage

// File: rtl/iosc_ready.sv
`timescale 1ns/1ps
module iosc_ready #(
  parameter int unsigned LIMIT = 1024,
  localparam int W = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  output logic ready
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (cnt != W'(LIMIT)) cnt <= cnt + W'(1);
  end

  assign ready = (cnt == W'(LIMIT));
endmodule

// File: rtl/iosc_postscale.sv
`timescale 1ns/1ps
module iosc_postscale
  import iosc_pkg::*;
#(
  parameter int HF_DIV_W    = 9,
  parameter int MF_LO_DIV_W = 4
) (
  input  logic              hf_clk,
  input  logic              mf_clk,
  input  logic              lf_clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] freq,
  input  logic [1:0]        lo_src,
  output logic              int_clk
);
  localparam int CODES = 2**CODE_W;

  logic [HF_DIV_W-1:0]    hf_cnt;
  logic [MF_LO_DIV_W-1:0] mf_cnt;
  logic [HF_DIV_W:0]      hf_taps;   // tap k = hf_clk / 2^k
  logic                   lo_clk;
  logic [CODES-1:0]       code_clk;

  always_ff @(posedge hf_clk or negedge rst_n) begin
    if (!rst_n) hf_cnt <= '0;
    else        hf_cnt <= hf_cnt + HF_DIV_W'(1);
  end

  always_ff @(posedge mf_clk or negedge rst_n) begin
    if (!rst_n) mf_cnt <= '0;
    else        mf_cnt <= mf_cnt + MF_LO_DIV_W'(1);
  end

  assign hf_taps = {hf_cnt, hf_clk};

  // Slowest rate: pick which reference supplies it.
  always_comb begin
    if (!lo_src[1])    lo_clk = lf_clk;
    else if (lo_src[0]) lo_clk = mf_cnt[MF_LO_DIV_W-1];
    else                lo_clk = hf_taps[HF_DIV_W];
  end

  assign code_clk[0] = lo_clk;
  for (genvar c = 1; c < CODES; c++) begin : g_code
    localparam int SH = post_shift(CODE_W'(c));
    assign code_clk[c] = hf_taps[SH];
  end

  assign int_clk = code_clk[freq];
endmodule

// File: rtl/iosc_clk_switch.sv
`timescale 1ns/1ps
module iosc_clk_switch #(
  parameter int N    = 3,
  parameter int SYNC = 2
) (
  input  logic [N-1:0] clks,
  input  logic         rst_n,
  input  logic [N-1:0] sel_oh,
  output logic         clk_out,
  output logic [N-1:0] en,
  output logic         busy
);
  logic [N-1:0] claim;   // source enabled or its request still in flight

  for (genvar g = 0; g < N; g++) begin : g_src
    localparam logic [N-1:0] OTHERS = ~(N'(1) << g);
    logic            req;
    logic [SYNC-1:0] sync_q;
    logic            en_q;

    assign req = sel_oh[g] & ~|(claim & OTHERS);

    always_ff @(posedge clks[g] or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC-2:0], req};
    end

    always_ff @(negedge clks[g] or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= sync_q[SYNC-1];
    end

    assign claim[g] = en_q | (|sync_q);
    assign en[g]    = en_q;
  end

  assign clk_out = |(clks & en);
  assign busy    = (en != sel_oh);
endmodule

// File: rtl/iosc_freq_sel.sv
`timescale 1ns/1ps
module iosc_freq_sel
  import iosc_pkg::*;
#(
  parameter int HF_DIV_W     = 9,
  parameter int MF_LO_DIV_W  = 4,
  parameter int READY_CYCLES = 1024,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       hf_clk,
  input  logic       mf_clk,
  input  logic       lf_clk,
  input  logic       pri_clk,
  input  logic       sec_clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [2:0] cfg_freq,
  input  logic [1:0] cfg_lo_src,
  input  logic [1:0] cfg_sys,
  output logic       intosc_clk,
  output logic       wdt_clk,
  output logic       sys_clk,
  output logic       switch_busy,
  output logic       hf_ready,
  output logic       mf_ready,
  output logic       lf_ready
);
  localparam logic [CODE_W-1:0] FREQ_RST = CODE_W'(3);   // 1 MHz

  logic [CODE_W-1:0] freq_q;
  logic [1:0]        lo_q;
  logic [1:0]        sys_q;
  logic [SRC_N-1:0]  sel_oh;
  logic [SRC_N-1:0]  sw_en;
  logic [SRC_N-1:0]  sw_clks;
  logic [2:0]        ref_clk;
  logic [2:0]        ready_v;

  always_ff @(posedge hf_clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_q <= FREQ_RST;
      lo_q   <= 2'b00;
      sys_q  <= 2'b00;
    end else if (cfg_wr) begin
      freq_q <= cfg_freq;
      lo_q   <= cfg_lo_src;
      sys_q  <= cfg_sys;
    end
  end

  assign sel_oh = sys_decode(sys_q);

  iosc_postscale #(
    .HF_DIV_W   (HF_DIV_W),
    .MF_LO_DIV_W(MF_LO_DIV_W)
  ) u_post (
    .hf_clk (hf_clk),
    .mf_clk (mf_clk),
    .lf_clk (lf_clk),
    .rst_n  (rst_n),
    .freq   (freq_q),
    .lo_src (lo_q),
    .int_clk(intosc_clk)
  );

  assign sw_clks[SRC_PRI] = pri_clk;
  assign sw_clks[SRC_SEC] = sec_clk;
  assign sw_clks[SRC_INT] = intosc_clk;

  iosc_clk_switch #(
    .N   (SRC_N),
    .SYNC(SYNC_STAGES)
  ) u_sw (
    .clks   (sw_clks),
    .rst_n  (rst_n),
    .sel_oh (sel_oh),
    .clk_out(sys_clk),
    .en     (sw_en),
    .busy   (switch_busy)
  );

  assign ref_clk = {lf_clk, mf_clk, hf_clk};
  for (genvar g = 0; g < 3; g++) begin : g_rdy
    iosc_ready #(.LIMIT(READY_CYCLES)) u_rdy (
      .clk  (ref_clk[g]),
      .rst_n(rst_n),
      .ready(ready_v[g])
    );
  end

  assign hf_ready = ready_v[0];
  assign mf_ready = ready_v[1];
  assign lf_ready = ready_v[2];
  assign wdt_clk  = lf_clk;
endmodule

// File: rtl/iosc_freq_sel_chk.sv
`timescale 1ns/1ps
module iosc_freq_sel_chk (
  input logic       hf_clk,
  input logic       rst_n,
  input logic       cfg_wr,
  input logic [2:0] freq_q,
  input logic [1:0] lo_q,
  input logic [1:0] sys_q,
  input logic [2:0] sel_oh,
  input logic [2:0] sw_en,
  input logic       switch_busy,
  input logic       hf_ready,
  input logic       mf_ready,
  input logic       lf_ready
);
  // R10: never two sources gated through at once
  a_r10_one_source: assert property (@(posedge hf_clk) disable iff (!rst_n)
    $onehot0(sw_en));

  // R10: a new selection is reported busy at once
  a_r10_busy_on_reselect: assert property (@(posedge hf_clk) disable iff (!rst_n)
    (sel_oh != $past(sel_oh)) |-> switch_busy);

  // R11: ready flags are sticky
  a_r11_hf_sticky: assert property (@(posedge hf_clk) disable iff (!rst_n)
    hf_ready |=> hf_ready);
  a_r11_mf_sticky: assert property (@(posedge hf_clk) disable iff (!rst_n)
    mf_ready |=> mf_ready);
  a_r11_lf_sticky: assert property (@(posedge hf_clk) disable iff (!rst_n)
    lf_ready |=> lf_ready);

  // R12: fields hold without a write strobe
  a_r12_hold: assert property (@(posedge hf_clk) disable iff (!rst_n)
    !cfg_wr |=> ($stable(freq_q) && $stable(lo_q) && $stable(sys_q)));

  // R5, R8: reset values of the configuration fields
  always @(posedge hf_clk) begin
    if (!rst_n) begin
      a_r5_reset_freq: assert (freq_q == 3'b011 && lo_q == 2'b00);
      a_r8_reset_sys:  assert (sys_q == 2'b00 && sw_en == 3'b000);
    end
  end
endmodule

bind iosc_freq_sel iosc_freq_sel_chk u_chk (
  .hf_clk     (hf_clk),
  .rst_n      (rst_n),
  .cfg_wr     (cfg_wr),
  .freq_q     (freq_q),
  .lo_q       (lo_q),
  .sys_q      (sys_q),
  .sel_oh     (sel_oh),
  .sw_en      (sw_en),
  .switch_busy(switch_busy),
  .hf_ready   (hf_ready),
  .mf_ready   (mf_ready),
  .lf_ready   (lf_ready)
);

// File: tb/iosc_freq_sel_tb.sv
`timescale 1ns/1ps
module iosc_freq_sel_tb;
  // Reference periods (ns): hf 4, mf 120, lf 2000, pri 10, sec 14
  logic hf_clk = 0, mf_clk = 0, lf_clk = 0, pri_clk = 0, sec_clk = 0;
  logic rst_n = 1;
  logic cfg_wr = 0;
  logic [2:0] cfg_freq = 3'b011;
  logic [1:0] cfg_lo_src = 2'b00, cfg_sys = 2'b00;
  logic intosc_clk, wdt_clk, sys_clk, switch_busy, hf_ready, mf_ready, lf_ready;

  always #2    hf_clk  = ~hf_clk;
  always #60   mf_clk  = ~mf_clk;
  always #1000 lf_clk  = ~lf_clk;
  always #5    pri_clk = ~pri_clk;
  always #7    sec_clk = ~sec_clk;

  iosc_freq_sel #(.READY_CYCLES(8)) u_dut (
    .hf_clk(hf_clk), .mf_clk(mf_clk), .lf_clk(lf_clk), .pri_clk(pri_clk),
    .sec_clk(sec_clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_freq(cfg_freq),
    .cfg_lo_src(cfg_lo_src), .cfg_sys(cfg_sys), .intosc_clk(intosc_clk),
    .wdt_clk(wdt_clk), .sys_clk(sys_clk), .switch_busy(switch_busy),
    .hf_ready(hf_ready), .mf_ready(mf_ready), .lf_ready(lf_ready)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Pulse-width monitor on sys_clk
  realtime last_t = 0, min_w = 1.0e9;
  bit mon_on = 0;
  always @(sys_clk) begin
    if (mon_on && last_t > 0 && ($realtime - last_t) < min_w) min_w = $realtime - last_t;
    if (mon_on) last_t = $realtime;
  end
  task automatic arm_mon();
    last_t = 0; min_w = 1.0e9; mon_on = 1;
  endtask

  task automatic wait_edge(input int which);
    if (which == 0)      @(posedge intosc_clk);
    else if (which == 1) @(posedge sys_clk);
    else                 @(posedge wdt_clk);
  endtask

  // Skip one edge (possible transient), then time one full period.
  task automatic period_of(input int which, output longint p);
    realtime t0;
    wait_edge(which);
    wait_edge(which);
    t0 = $realtime;
    wait_edge(which);
    p = longint'($realtime - t0);
  endtask

  task automatic cfg_write(input logic [2:0] f, input logic [1:0] lo, input logic [1:0] s);
    @(negedge hf_clk);
    cfg_wr = 1; cfg_freq = f; cfg_lo_src = lo; cfg_sys = s;
    @(negedge hf_clk);
    cfg_wr = 0;
  endtask

  task automatic wait_idle(output bit ok);
    ok = 0;
    for (int i = 0; i < 5000; i++) begin
      if (!switch_busy) begin ok = 1; break; end
      @(negedge hf_clk);
    end
  endtask

  // {rate code, source field, expected intosc period in ns}
  localparam logic [20:0] VEC [12] = '{
    {3'b111, 2'b00, 16'd4},    {3'b110, 2'b00, 16'd8},
    {3'b101, 2'b00, 16'd16},   {3'b100, 2'b00, 16'd32},
    {3'b011, 2'b00, 16'd64},   {3'b010, 2'b00, 16'd128},
    {3'b001, 2'b00, 16'd256},  {3'b001, 2'b11, 16'd256},
    {3'b000, 2'b00, 16'd2000}, {3'b000, 2'b01, 16'd2000},
    {3'b000, 2'b10, 16'd2048}, {3'b000, 2'b11, 16'd1920}
  };

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #600000;
    n_chk++; n_bad++;
    $display("FAIL watchdog (all requirements): run did not complete");
    finish_run();
  end

  initial begin
    longint p;
    bit ok;
    #1 rst_n = 0;
    #50;
    // R8 / R11: state while reset is held
    check(switch_busy === 1'b1, "R8 busy in reset", switch_busy, 1);
    check(sys_clk === 1'b0, "R8 sys_clk low in reset", sys_clk, 0);
    check({hf_ready, mf_ready, lf_ready} === 3'b000, "R11 ready low in reset",
          {hf_ready, mf_ready, lf_ready}, 0);
    #50 rst_n = 1;                       // released at t=101
    #12;
    check(hf_ready === 1'b0, "R11 hf_ready before count", hf_ready, 0);
    #88;
    check(hf_ready === 1'b1, "R11 hf_ready after count", hf_ready, 1);
    check(lf_ready === 1'b0, "R11 lf_ready still counting", lf_ready, 0);

    // R8: primary after reset
    wait_idle(ok);
    check(ok, "R8 primary switch completes", ok, 1);
    period_of(1, p);
    check(p == 10, "R8 sys_clk follows pri_clk", p, 10);
    // R5: 1 MHz default
    period_of(0, p);
    check(p == 64, "R5 default intosc period", p, 64);

    // R1-R4 vector walk
    for (int i = 0; i < 12; i++) begin
      string tag;
      cfg_write(VEC[i][20:18], VEC[i][17:16], 2'b00);
      if (VEC[i][20:18] != 3'b000) tag = "R1";
      else if (!VEC[i][17])        tag = "R2";
      else if (!VEC[i][16])        tag = "R3";
      else                         tag = "R4";
      period_of(0, p);
      check(p == longint'(VEC[i][15:0]), $sformatf("%s intosc period vec %0d", tag, i),
            p, longint'(VEC[i][15:0]));
      @(negedge hf_clk);
      check(wdt_clk === lf_clk, "R6 wdt_clk tracks lf_clk", wdt_clk, lf_clk);
    end
    // R6: period unaffected by source field (currently 000/11)
    period_of(2, p);
    check(p == 2000, "R6 wdt period", p, 2000);

    // R12: inputs without strobe are ignored
    cfg_write(3'b011, 2'b00, 2'b00);
    @(negedge hf_clk);
    cfg_freq = 3'b111; cfg_sys = 2'b01; cfg_lo_src = 2'b11;
    repeat (20) @(negedge hf_clk);
    check(switch_busy === 1'b0, "R12 no switch without strobe", switch_busy, 0);
    period_of(0, p);
    check(p == 64, "R12 intosc rate held", p, 64);
    period_of(1, p);
    check(p == 10, "R12 sys source held", p, 10);

    // R9/R10: primary -> secondary
    arm_mon();
    cfg_write(3'b011, 2'b00, 2'b01);
    check(switch_busy === 1'b1, "R10 busy after reselect", switch_busy, 1);
    wait_idle(ok);
    check(ok, "R10 switch to sec completes", ok, 1);
    period_of(1, p);
    check(p == 14, "R9 01 selects sec_clk", p, 14);
    mon_on = 0;
    check(min_w >= 4.9, "R10 no short pulse pri->sec", longint'(min_w), 5);

    // secondary -> internal
    arm_mon();
    cfg_write(3'b011, 2'b00, 2'b10);
    check(switch_busy === 1'b1, "R10 busy sec->int", switch_busy, 1);
    wait_idle(ok);
    check(ok, "R10 switch to int completes", ok, 1);
    period_of(1, p);
    check(p == 64, "R9 10 selects intosc", p, 64);
    mon_on = 0;
    check(min_w >= 6.9, "R10 no short pulse sec->int", longint'(min_w), 7);

    // 10 -> 11: same source
    cfg_write(3'b011, 2'b00, 2'b11);
    check(switch_busy === 1'b0, "R9 11 keeps intosc without switch", switch_busy, 1'b0);
    period_of(1, p);
    check(p == 64, "R9 11 selects intosc", p, 64);

    // R7: immediate rate change on the running system clock
    cfg_write(3'b111, 2'b00, 2'b11);
    check(switch_busy === 1'b0, "R7 no busy on rate change", switch_busy, 0);
    period_of(1, p);
    check(p == 4, "R7 sys_clk at new rate", p, 4);

    // internal -> primary
    cfg_write(3'b011, 2'b00, 2'b11);
    repeat (4) @(negedge hf_clk);
    arm_mon();
    cfg_write(3'b011, 2'b00, 2'b00);
    check(switch_busy === 1'b1, "R10 busy int->pri", switch_busy, 1);
    wait_idle(ok);
    check(ok, "R10 switch to pri completes", ok, 1);
    period_of(1, p);
    check(p == 10, "R9 00 selects pri_clk", p, 10);
    mon_on = 0;
    check(min_w >= 4.9, "R10 no short pulse int->pri", longint'(min_w), 5);

    // R11: slow references ready by now
    check(mf_ready === 1'b1, "R11 mf_ready", mf_ready, 1);
    check(lf_ready === 1'b1, "R11 lf_ready", lf_ready, 1);
    finish_run();
  end
endmodule